// File: doc/BRIEF.md
# Odd/Even Planar Address Mapper

This block sits between the host byte-access path and a four-plane video memory. It turns each host byte access into a plane number and a memory byte address for the two odd/even addressing styles. In the chained style, host address bit 0 picks one plane of a pair, and a page bit picks which pair. In the unchained style, only the page bit picks the plane, and the whole host address moves up two bit positions.

Three small control registers are written through a shared configuration port: a mode register, a plane write mask and a page/extension register. The block checks each translated address against the base-memory size, against a limit set by configuration, and (for writes through the legacy window) against the window bounds. A blocked write never reaches memory. A blocked read returns all ones. A linear-aperture flag wraps the translated address to the memory size and skips the window check. All memory-side outputs are registered. The memory has a synchronous write and an asynchronous read.

Top module: `plane_addr_mapper`

## Requirements
- R1: A configuration write with `cfg_sel_i`=0 loads the chain flag from `cfg_wdata_i[1]`. With select 1 it loads the plane write mask from `cfg_wdata_i[3:0]` (bit n enables plane n). With select 2 it loads the page bit from `cfg_wdata_i[0]` and the extended-memory enable from `cfg_wdata_i[1]`. The new value applies to requests issued after the write clock edge.
- R2: The plane index is {page, host_addr[0]} when chaining is on and {page, 0} when it is off. It appears on `mem_plane_o`.
- R3: The translated address is ((host_addr with bit 0 cleared) << 2) | plane when chaining is on, and (host_addr << 2) | plane when it is off.
- R4: A write reaches memory (`mem_we_o`=1) only if mask bit [plane] is set.
- R5: With extended memory disabled, a translated address of 0x10000 or above is blocked.
- R6: A translated address at or above `vram_limit_i` is blocked.
- R7: A non-linear write is dropped unless 0xA0000 < host_addr < 0xBFFFF, both bounds exclusive. Reads are not window-checked.
- R8: When `req_linear_i`=1, the translated address is cut to its low 23 bits before the R5 and R6 checks, and the R7 window check is skipped.
- R9: `mem_we_o`, `mem_re_o`, `mem_addr_o`, `mem_plane_o`, `mem_wdata_o` and `rd_valid_o` are registered. They show a request one cycle after its strobe. A new request is accepted every cycle, and an idle cycle yields no strobe.
- R10: A read ignores the write mask. An accepted read raises `mem_re_o` and returns `mem_rdata_i` on `rd_data_o`. A blocked read keeps `mem_re_o` low and returns 0xFF. `rd_valid_o` marks every read.
- R11: After reset the chain flag is 0, the page bit is 0, the write mask is 0xF and extended memory is disabled. No memory strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 2 | Control register select (0 mode, 1 mask, 2 page/ext) |
| cfg_wdata_i | input | 8 | Control register write data |
| vram_limit_i | input | 24 | Installed memory size; translated addresses at or above are blocked |
| req_we_i | input | 1 | Host byte write strobe |
| req_re_i | input | 1 | Host byte read strobe |
| req_linear_i | input | 1 | Request comes through the linear aperture |
| req_addr_i | input | 24 | Host byte address |
| req_wdata_i | input | 8 | Host write data |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_re_o | output | 1 | Memory byte read enable |
| mem_addr_o | output | 23 | Memory byte address |
| mem_plane_o | output | 2 | Selected plane |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data for `mem_addr_o` |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Read result (0xFF when blocked) |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. The bench drives exactly one strobe per access, so it stays within that assumption. The mask, extension and limit checks compare against the configuration held one cycle earlier. This holds whether or not a configuration write lands at the same edge as a request, and the bench changes configuration only between accesses. The sweeps cover both chain settings, both pages and all sixteen masks over a spread of window addresses. They then hit each range bound from one step below and at the bound itself.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int NUM_PLANES = 4;
  localparam int PLANE_W    = $clog2(NUM_PLANES);

  typedef enum logic [1:0] {
    CFG_MODE = 2'd0,
    CFG_MASK = 2'd1,
    CFG_PAGE = 2'd2
  } cfg_sel_e;

  typedef struct packed {
    logic                  chain;
    logic                  page;
    logic                  ext_en;
    logic [NUM_PLANES-1:0] mask;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{chain: 1'b0, page: 1'b0, ext_en: 1'b0, mask: '1};
endpackage

// File: rtl/vmap_ctrl_regs.sv
module vmap_ctrl_regs
  import vmap_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [1:0]   cfg_sel_i,
  input  logic [7:0]   cfg_wdata_i,
  output ctrl_t        ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (cfg_we_i) begin
      unique case (cfg_sel_e'(cfg_sel_i))
        CFG_MODE: ctrl_d.chain = cfg_wdata_i[1];
        CFG_MASK: ctrl_d.mask  = cfg_wdata_i[NUM_PLANES-1:0];
        CFG_PAGE: begin
          ctrl_d.page   = cfg_wdata_i[0];
          ctrl_d.ext_en = cfg_wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R1
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == 2'd0) |=> (ctrl_q.chain == $past(cfg_wdata_i[1])));
  // R1
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == 2'd1) |=> $stable(ctrl_q.mask));
endmodule

// File: rtl/vmap_xlate.sv
module vmap_xlate
  import vmap_pkg::*;
#(
  parameter int HOST_AW = 24,
  localparam int XW     = HOST_AW + PLANE_W
) (
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               chain_i,
  input  logic               page_i,
  output logic [PLANE_W-1:0] plane_o,
  output logic [XW-1:0]      xaddr_o
);
  always_comb begin
    if (chain_i) begin
      plane_o = {page_i, addr_i[0]};
      xaddr_o = {addr_i[HOST_AW-1:1], 1'b0, plane_o};
    end else begin
      plane_o = {page_i, 1'b0};
      xaddr_o = {addr_i, plane_o};
    end
  end
endmodule

// File: rtl/vmap_guard.sv
module vmap_guard
  import vmap_pkg::*;
#(
  parameter int HOST_AW  = 24,
  parameter int VRAM_AW  = 23,
  parameter int EXT_BASE = 'h10000,
  parameter int WIN_LO   = 'hA0000,
  parameter int WIN_HI   = 'hBFFFF,
  localparam int XW      = HOST_AW + PLANE_W,
  localparam int LW      = VRAM_AW + 1,
  localparam int CW      = (XW > LW) ? XW : LW
) (
  input  logic [HOST_AW-1:0]    raw_addr_i,
  input  logic [XW-1:0]         xaddr_i,
  input  logic                  linear_i,
  input  logic                  is_write_i,
  input  logic                  ext_en_i,
  input  logic [LW-1:0]         limit_i,
  input  logic [NUM_PLANES-1:0] mask_i,
  input  logic [PLANE_W-1:0]    plane_i,
  output logic [VRAM_AW-1:0]    addr_o,
  output logic                  blocked_o,
  output logic                  mask_hit_o
);
  logic [CW-1:0] chk_addr;
  logic          ext_blk, lim_blk, win_blk, in_win;

  generate
    if (XW > VRAM_AW) begin : g_wrap
      always_comb chk_addr = linear_i ? CW'(xaddr_i[VRAM_AW-1:0]) : CW'(xaddr_i);
    end else begin : g_nowrap
      always_comb chk_addr = CW'(xaddr_i);
    end
  endgenerate

  assign in_win     = (raw_addr_i > HOST_AW'(WIN_LO)) && (raw_addr_i < HOST_AW'(WIN_HI));
  assign ext_blk    = !ext_en_i && (chk_addr >= CW'(EXT_BASE));
  assign lim_blk    = chk_addr >= CW'(limit_i);
  assign win_blk    = is_write_i && !linear_i && !in_win;
  assign blocked_o  = ext_blk || lim_blk || win_blk;
  assign mask_hit_o = mask_i[plane_i];
  assign addr_o     = chk_addr[VRAM_AW-1:0];
endmodule

// File: rtl/plane_addr_mapper.sv
module plane_addr_mapper
  import vmap_pkg::*;
#(
  parameter int HOST_AW  = 24,
  parameter int VRAM_AW  = 23,
  parameter int EXT_BASE = 'h10000,
  parameter int WIN_LO   = 'hA0000,
  parameter int WIN_HI   = 'hBFFFF,
  localparam int XW      = HOST_AW + PLANE_W,
  localparam int LW      = VRAM_AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [7:0]         cfg_wdata_i,
  input  logic [LW-1:0]      vram_limit_i,
  input  logic               req_we_i,
  input  logic               req_re_i,
  input  logic               req_linear_i,
  input  logic [HOST_AW-1:0] req_addr_i,
  input  logic [7:0]         req_wdata_i,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [VRAM_AW-1:0] mem_addr_o,
  output logic [PLANE_W-1:0] mem_plane_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i,
  output logic               rd_valid_o,
  output logic [7:0]         rd_data_o
);
  ctrl_t               ctrl;
  logic [PLANE_W-1:0]  plane;
  logic [XW-1:0]       xaddr;
  logic [VRAM_AW-1:0]  gaddr;
  logic                blocked, mask_hit, rd_blk_q;

  vmap_ctrl_regs u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_wdata_i, .ctrl_o(ctrl)
  );

  vmap_xlate #(.HOST_AW(HOST_AW)) u_xlate (
    .addr_i(req_addr_i), .chain_i(ctrl.chain), .page_i(ctrl.page),
    .plane_o(plane), .xaddr_o(xaddr)
  );

  vmap_guard #(
    .HOST_AW(HOST_AW), .VRAM_AW(VRAM_AW), .EXT_BASE(EXT_BASE),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_guard (
    .raw_addr_i(req_addr_i), .xaddr_i(xaddr), .linear_i(req_linear_i),
    .is_write_i(req_we_i), .ext_en_i(ctrl.ext_en), .limit_i(vram_limit_i),
    .mask_i(ctrl.mask), .plane_i(plane),
    .addr_o(gaddr), .blocked_o(blocked), .mask_hit_o(mask_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o    <= 1'b0;
      mem_re_o    <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_blk_q    <= 1'b0;
      mem_addr_o  <= '0;
      mem_plane_o <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o   <= req_we_i && !blocked && mask_hit;
      mem_re_o   <= req_re_i && !req_we_i && !blocked;
      rd_valid_o <= req_re_i && !req_we_i;
      if (req_we_i || req_re_i) begin
        mem_addr_o  <= gaddr;
        mem_plane_o <= plane;
        rd_blk_q    <= blocked;
      end
      if (req_we_i) mem_wdata_o <= req_wdata_i;
    end
  end

  assign rd_data_o = rd_blk_q ? 8'hFF : mem_rdata_i;

  // R9
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_we_i && req_re_i));
  // R9
  we_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(req_we_i));
  // R10
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(req_re_i) && !mem_we_o));
  // R4
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((($past(ctrl.mask) >> mem_plane_o) & 4'd1) != 4'd0));
  // R2
  page_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (mem_plane_o[PLANE_W-1] == $past(ctrl.page)));
  // R5
  ext_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_we_o || mem_re_o) && !$past(ctrl.ext_en)) |-> (mem_addr_o < VRAM_AW'(EXT_BASE)));
  // R6
  limit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (LW'(mem_addr_o) < $past(vram_limit_i)));
  // R10
  blk_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !mem_re_o) |-> (rd_data_o == 8'hFF));
endmodule

// File: tb/plane_addr_mapper_test.sv
`timescale 1ns/1ps
module plane_addr_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [23:0] lim = 24'h800000;
  logic        req_we = 1'b0, req_re = 1'b0, req_lin = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        mem_we, mem_re, rd_valid;
  logic [22:0] mem_addr;
  logic [1:0]  mem_plane;
  logic [7:0]  mem_wdata, mem_rdata, rd_data;
  logic [7:0]  tbmem [0:4095];

  int checks = 0;
  int fails  = 0;

  bit       m_chain = 0, m_page = 0, m_ext = 0;
  bit [3:0] m_mask = 4'hF;

  always #2 clk = ~clk;

  plane_addr_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .vram_limit_i(lim), .req_we_i(req_we),
    .req_re_i(req_re), .req_linear_i(req_lin), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .mem_we_o(mem_we), .mem_re_o(mem_re),
    .mem_addr_o(mem_addr), .mem_plane_o(mem_plane), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  initial for (int i = 0; i < 4096; i++) tbmem[i] = 8'(i * 7 + 3);
  always @(posedge clk) if (mem_we) tbmem[mem_addr[11:0]] <= mem_wdata;
  assign mem_rdata = tbmem[mem_addr[11:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == 2'd0) m_chain = d[1];
    if (sel == 2'd1) m_mask  = d[3:0];
    if (sel == 2'd2) begin m_page = d[0]; m_ext = d[1]; end
  endtask

  // drive at a negedge, check at the next one; consecutive calls are back-to-back
  task automatic access(input bit wr, input bit lin, input logic [23:0] a,
                        input logic [7:0] d, input string req);
    logic [1:0]  p;
    logic [25:0] xa;
    bit          blk, we_exp;
    logic [7:0]  rd_exp;
    p  = m_chain ? {m_page, a[0]} : {m_page, 1'b0};
    xa = m_chain ? {a[23:1], 1'b0, p} : {a, p};
    if (lin) xa = {3'b0, xa[22:0]};
    blk = (!m_ext && xa >= 26'h10000) || (xa >= 26'(lim)) ||
          (wr && !lin && !(a > 24'hA0000 && a < 24'hBFFFF));
    we_exp = wr && !blk && m_mask[p];
    req_we = wr; req_re = !wr; req_lin = lin; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_we = 1'b0; req_re = 1'b0; req_lin = 1'b0;
    if (wr) begin
      chk(mem_we == we_exp, req, "write enable", mem_we, we_exp);
      chk(!rd_valid, req, "no read valid on write", rd_valid, 0);
      if (we_exp) begin
        chk(mem_plane == p, req, "plane", mem_plane, p);
        chk(mem_addr == xa[22:0], req, "address", mem_addr, xa[22:0]);
        chk(mem_wdata == d, req, "write data", mem_wdata, d);
      end
    end else begin
      rd_exp = blk ? 8'hFF : tbmem[xa[11:0]];
      chk(rd_valid, req, "read valid", rd_valid, 1);
      chk(mem_re == !blk, req, "read enable", mem_re, !blk);
      chk(!mem_we, req, "no write on read", mem_we, 0);
      if (!blk) begin
        chk(mem_plane == p, req, "plane", mem_plane, p);
        chk(mem_addr == xa[22:0], req, "address", mem_addr, xa[22:0]);
      end
      chk(rd_data == rd_exp, req, "read data", rd_data, rd_exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!mem_we && !mem_re && !rd_valid, "R11", "strobes idle", {mem_we, mem_re, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_we && !mem_re && !rd_valid, "R11", "strobes after release", {mem_we, mem_re, rd_valid}, 0);
    access(0, 1, 24'h000001, 8'h00, "R11");         // chain0 page0: plane 0, addr 4
    chk(mem_plane == 2'd0 && mem_addr == 23'h4, "R11", "default mapping", mem_addr, 4);
    access(1, 1, 24'h000010, 8'h5A, "R11");         // mask 0xF: write goes through
    chk(mem_we, "R11", "default mask", mem_we, 1);
    access(1, 1, 24'h004000, 8'h11, "R11");         // 0x10000 blocked, ext off
    chk(!mem_we, "R11", "ext disabled", mem_we, 0);

    // R2 R3 R4 R10 sweep: chain x page x mask x addresses, writes then reads
    for (int c = 0; c < 2; c++)
      for (int pg = 0; pg < 2; pg++) begin
        cfg(2'd0, c[0] ? 8'h02 : 8'hFD);           // R1 only bit 1 matters
        cfg(2'd2, {6'b0, 1'b1, pg[0]});
        for (int m = 0; m < 16; m++) begin
          cfg(2'd1, {4'hF, m[3:0]});
          for (int k = 0; k < 9; k++) begin
            logic [23:0] a;
            a = (k == 8) ? 24'hBFFFE : 24'hA0001 + 24'(k);
            access(1, 0, a, 8'(m * 16 + k + c * 3 + pg), "R4");
            access(0, 0, a, 8'h00, "R10");
          end
        end
      end
    chk(checks > 2000, "R2", "sweep ran", checks, 2000);

    // R1 + R3 odd/even readback, R10 read ignores mask
    cfg(2'd0, 8'h02); cfg(2'd2, 8'h02); cfg(2'd1, 8'h0F);
    access(1, 0, 24'hA0002, 8'h3C, "R3");
    access(1, 0, 24'hA0003, 8'hC3, "R3");
    access(0, 0, 24'hA0002, 8'h00, "R3");
    chk(rd_data == 8'h3C && mem_addr == 23'h280008, "R3", "even byte plane0", rd_data, 8'h3C);
    access(0, 0, 24'hA0003, 8'h00, "R3");
    chk(rd_data == 8'hC3 && mem_addr == 23'h280009, "R3", "odd byte plane1", rd_data, 8'hC3);
    cfg(2'd1, 8'h00);
    access(1, 0, 24'hA0002, 8'hEE, "R4");
    chk(!mem_we, "R4", "mask 0 drops write", mem_we, 0);
    access(0, 0, 24'hA0002, 8'h00, "R10");
    chk(rd_data == 8'h3C && mem_re, "R10", "read ignores mask", rd_data, 8'h3C);
    cfg(2'd1, 8'h0F);

    // R7 window bounds
    cfg(2'd0, 8'h00);
    access(1, 0, 24'hA0000, 8'h01, "R7"); chk(!mem_we, "R7", "low bound", mem_we, 0);
    access(1, 0, 24'hA0001, 8'h02, "R7"); chk(mem_we,  "R7", "low+1",     mem_we, 1);
    access(1, 0, 24'hBFFFE, 8'h03, "R7"); chk(mem_we,  "R7", "high-1",    mem_we, 1);
    access(1, 0, 24'hBFFFF, 8'h04, "R7"); chk(!mem_we, "R7", "high bound", mem_we, 0);
    access(0, 0, 24'hBFFFF, 8'h00, "R7"); chk(mem_re,  "R7", "read not window checked", mem_re, 1);

    // R5 extension bound (linear, unchained page 0 and chained page 1)
    cfg(2'd2, 8'h00);
    access(1, 1, 24'h003FFF, 8'h21, "R5"); chk(mem_we && mem_addr == 23'hFFFC, "R5", "below 0x10000", mem_addr, 23'hFFFC);
    access(1, 1, 24'h004000, 8'h22, "R5"); chk(!mem_we, "R5", "at 0x10000", mem_we, 0);
    access(0, 1, 24'h004000, 8'h00, "R5"); chk(rd_data == 8'hFF && !mem_re, "R5", "blocked read", rd_data, 8'hFF);
    cfg(2'd0, 8'h02); cfg(2'd2, 8'h01);
    access(1, 1, 24'h003FFF, 8'h23, "R5"); chk(mem_we && mem_addr == 23'hFFFB, "R5", "chained below", mem_addr, 23'hFFFB);

    // R6 limit bound: chained page1, 0xBFFFE -> 0x2FFFFA
    cfg(2'd2, 8'h03);
    lim = 24'h2FFFFA;
    access(1, 0, 24'hBFFFE, 8'h31, "R6"); chk(!mem_we, "R6", "at limit", mem_we, 0);
    access(0, 0, 24'hBFFFE, 8'h00, "R6"); chk(rd_data == 8'hFF, "R6", "read at limit", rd_data, 8'hFF);
    lim = 24'h2FFFFB;
    access(1, 0, 24'hBFFFE, 8'h32, "R6"); chk(mem_we && mem_addr == 23'h2FFFFA, "R6", "below limit", mem_addr, 23'h2FFFFA);
    lim = 24'h800000;

    // R8 linear wrap and no window check
    cfg(2'd0, 8'h00); cfg(2'd2, 8'h00);
    access(1, 1, 24'h200001, 8'h41, "R8"); chk(mem_we && mem_addr == 23'h4, "R8", "wrap to 23 bits", mem_addr, 4);
    access(0, 0, 24'h200001, 8'h00, "R8"); chk(rd_data == 8'hFF, "R8", "non-linear not wrapped", rd_data, 8'hFF);
    access(1, 1, 24'h000001, 8'h42, "R8"); chk(mem_we, "R8", "linear outside window", mem_we, 1);

    // R9 back-to-back then idle
    cfg(2'd2, 8'h02);
    access(1, 0, 24'hA0005, 8'h51, "R9");
    access(1, 0, 24'hA0006, 8'h52, "R9");
    chk(mem_we && mem_addr == 23'h280018, "R9", "second of pair", mem_addr, 23'h280018);
    @(negedge clk);
    chk(!mem_we && !mem_re && !rd_valid, "R9", "idle cycle", {mem_we, mem_re, rd_valid}, 0);

    summary();
  end
endmodule